// File: doc/BRIEF.md
# Watchdog Timer with Magic-Sequence Start/Stop

This block is a watchdog peripheral. An up-counter advances on a slow timebase tick, and an optional power-of-two prescaler can slow it further. If software does not reload the counter before it wraps past all-ones, the block raises a reset request for a fixed number of clock cycles. After that it returns to its power-on state, which is running with the default load value.

Software reaches the block through a simple word-addressed register bus. Writes are single cycle and reads are combinational.

- Starting and stopping the counter requires a pair of magic values written in order to one register.
- Writing the trigger register with a new value reloads the counter from the load register.
- The control and load registers are locked while the counter runs.
- Each write to a register raises a per-register busy flag in a status register for a fixed number of cycles. This models the delay of a posted write crossing clock domains.

Top module: `guard_timer`

## Requirements
- R1: After reset the block is running, the counter and the load register both hold DEF_LOAD (default 0xFFFF_FFF0), control reads 0, status reads 0, the trigger register reads 0 and `wdt_rst` is low.
- R2: Address 0 reads the revision code REV (default 0x31) in bits 7:0, with zeros above.
- R3: At address 6, writing 0x0000_BBBB and then 0x0000_4444 starts the counter, and writing 0x0000_AAAA and then 0x0000_5555 stops it. All 32 bits are compared.
- R4: When the write that follows a first magic value is not the matching second value, the sequence is dropped and that write is not taken as a new first value.
- R5: Control (address 1) and load (address 3) take writes only while the counter is stopped. Control bit 5 enables the prescaler, bits 4:2 hold the ratio, and all other bits read 0.
- R6: Writing the trigger register (address 5) with a value that differs from its current contents copies the load register into the counter. Writing the same value has no effect on the counter.
- R7: While running with the prescaler off, each cycle in which `tick` is high adds 1 to the counter (address 4). While stopped, the counter holds its value.
- R8: With control bit 5 set, the counter advances once every 2^ratio ticks. The prescale phase restarts on a reload and on a start.
- R9: Status (address 2) has busy bits at bit 0 (control), bit 2 (load), bit 3 (trigger) and bit 4 (start/stop). Each bit reads 1 for exactly 4 cycles after a write to its register is accepted, including writes that are ignored under R5.
- R10: A count step taken at 0xFFFF_FFFF sets the counter to 0 and drives `wdt_rst` high for RST_CYC cycles (default 8). During that time bus writes are ignored. After it, the block returns to its R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
A wrong run flag is visible in the counter register within one tick, because the count either moves when it should hold or holds when it should move. Faults in the sequence checker show up as the same symptom after the second magic write. A slip in the prescale phase shifts which tick increments the counter by one position. A busy-flag length error is visible in the status register on the fourth or fifth cycle after a write. The restore after a reset pulse is checked on the first cycle after `wdt_rst` falls, by reading the counter, load and control registers.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int DW     = 32;
    localparam int AW     = 3;
    localparam int STAT_W = 5;
    localparam int RAT_W  = 3;

    localparam logic [AW-1:0] A_REV   = 3'd0;
    localparam logic [AW-1:0] A_CTRL  = 3'd1;
    localparam logic [AW-1:0] A_STAT  = 3'd2;
    localparam logic [AW-1:0] A_LOAD  = 3'd3;
    localparam logic [AW-1:0] A_COUNT = 3'd4;
    localparam logic [AW-1:0] A_TRIG  = 3'd5;
    localparam logic [AW-1:0] A_SS    = 3'd6;

    localparam logic [DW-1:0] EN_FIRST   = 32'h0000_BBBB;
    localparam logic [DW-1:0] EN_SECOND  = 32'h0000_4444;
    localparam logic [DW-1:0] DIS_FIRST  = 32'h0000_AAAA;
    localparam logic [DW-1:0] DIS_SECOND = 32'h0000_5555;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_EN, SEQ_DIS} seq_e;
endpackage

// File: rtl/guard_seq.sv
module guard_seq
    import guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          en_pulse,
    output logic          dis_pulse
);
    seq_e st_q, st_d;

    always_comb begin
        st_d      = st_q;
        en_pulse  = 1'b0;
        dis_pulse = 1'b0;
        if (clr) begin
            st_d = SEQ_IDLE;
        end else if (wr) begin
            case (st_q)
                SEQ_EN: begin
                    en_pulse = (wdata == EN_SECOND);
                    st_d     = SEQ_IDLE;
                end
                SEQ_DIS: begin
                    dis_pulse = (wdata == DIS_SECOND);
                    st_d      = SEQ_IDLE;
                end
                default: begin
                    if (wdata == EN_FIRST)       st_d = SEQ_EN;
                    else if (wdata == DIS_FIRST) st_d = SEQ_DIS;
                    else                         st_d = SEQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/guard_prescale.sv
module guard_prescale
    import guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic             div_en,
    input  logic [RAT_W-1:0] ratio,
    output logic             step
);
    localparam int PRE_W = (1 << RAT_W) - 1;

    logic [PRE_W-1:0] pre_q, pre_d, lim;

    always_comb begin
        lim = '0;
        for (int i = 0; i < PRE_W; i++)
            if (i < int'(ratio)) lim[i] = 1'b1;
    end

    always_comb begin
        step  = run && tick && (!div_en || (pre_q == lim));
        pre_d = pre_q;
        if (clr || restart)
            pre_d = '0;
        else if (run && tick && div_en)
            pre_d = (pre_q == lim) ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/guard_pending.sv
module guard_pending #(
    parameter int SLOTS = 5,
    parameter int DLY   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SLOTS-1:0] hit,
    output logic [SLOTS-1:0] busy
);
    localparam int CW = $clog2(DLY + 1);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [CW-1:0] cnt_q, cnt_d;

        always_comb begin
            cnt_d = cnt_q;
            if (clr)              cnt_d = '0;
            else if (hit[g])      cnt_d = CW'(DLY);
            else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign busy[g] = (cnt_q != '0);
    end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter logic [31:0] DEF_LOAD = 32'hFFFF_FFF0,
    parameter logic [7:0]  REV      = 8'h31,
    parameter int          RST_CYC  = 8,
    parameter int          PEND_DLY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          wdt_rst
);
    localparam int RW = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic             div_en;
        logic [RAT_W-1:0] ratio;
        logic [DW-1:0]    load;
        logic [DW-1:0]    count;
        logic [DW-1:0]    trig;
        logic             run;
        logic [RW-1:0]    rcnt;
    } st_t;

    localparam st_t RST_ST = '{div_en: 1'b0, ratio: '0, load: DEF_LOAD,
                               count: DEF_LOAD, trig: '0, run: 1'b1, rcnt: '0};

    st_t st_q, st_d;

    logic pulse, clr, acc;
    logic w_ctrl, w_load, w_trig, w_ss, reload;
    logic en_pulse, dis_pulse, step;
    logic [STAT_W-1:0] stat, pend_hit;

    assign pulse  = (st_q.rcnt != '0);
    assign clr    = (st_q.rcnt == RW'(1));
    assign acc    = we && !pulse;
    assign w_ctrl = acc && (addr == A_CTRL);
    assign w_load = acc && (addr == A_LOAD);
    assign w_trig = acc && (addr == A_TRIG);
    assign w_ss   = acc && (addr == A_SS);
    assign reload = w_trig && (wdata != st_q.trig);
    assign pend_hit = {w_ss, w_trig, w_load, 1'b0, w_ctrl};

    guard_seq u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr(w_ss), .wdata(wdata),
        .en_pulse(en_pulse), .dis_pulse(dis_pulse)
    );

    guard_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .restart(reload || en_pulse),
        .run(st_q.run), .tick(tick), .div_en(st_q.div_en), .ratio(st_q.ratio),
        .step(step)
    );

    guard_pending #(.SLOTS(STAT_W), .DLY(PEND_DLY)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hit(pend_hit), .busy(stat)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = RST_ST;
        end else if (pulse) begin
            st_d.rcnt = st_q.rcnt - 1'b1;
        end else begin
            if (w_ctrl && !st_q.run) begin
                st_d.div_en = wdata[5];
                st_d.ratio  = wdata[4:2];
            end
            if (w_load && !st_q.run) st_d.load = wdata;
            if (w_trig)              st_d.trig = wdata;
            if (en_pulse)            st_d.run  = 1'b1;
            if (dis_pulse)           st_d.run  = 1'b0;
            if (reload) begin
                st_d.count = st_q.load;
            end else if (step) begin
                if (&st_q.count) begin
                    st_d.count = '0;
                    st_d.run   = 1'b0;
                    st_d.rcnt  = RW'(RST_CYC);
                end else begin
                    st_d.count = st_q.count + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_REV:   rdata = {{(DW-8){1'b0}}, REV};
            A_CTRL:  rdata = {{(DW-6){1'b0}}, st_q.div_en, st_q.ratio, 2'b00};
            A_STAT:  rdata = {{(DW-STAT_W){1'b0}}, stat};
            A_LOAD:  rdata = st_q.load;
            A_COUNT: rdata = st_q.count;
            A_TRIG:  rdata = st_q.trig;
            default: rdata = '0;
        endcase
    end

    assign wdt_rst = pulse;

    logic              chk_run;
    logic [DW-1:0]     chk_count, chk_load;
    logic [RAT_W:0]    chk_ctrl;
    logic [STAT_W-1:0] chk_stat;
    assign chk_run   = st_q.run;
    assign chk_count = st_q.count;
    assign chk_load  = st_q.load;
    assign chk_ctrl  = {st_q.div_en, st_q.ratio};
    assign chk_stat  = stat;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
    import guard_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [AW-1:0]     addr,
    input logic              wdt_rst,
    input logic              run,
    input logic [DW-1:0]     count,
    input logic [DW-1:0]     load,
    input logic [RAT_W:0]    ctrl,
    input logic [STAT_W-1:0] stat
);
    a_r10_wrap_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> (count == '0 && $past(count) == '1));

    a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(load) && $stable(ctrl)));

    a_r7_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wdt_rst && !(we && addr == A_TRIG)) |=> $stable(count));

    a_r9_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdt_rst && addr == A_LOAD) |=> stat[2]);

    a_r9_trig_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdt_rst && addr == A_TRIG) |=> stat[3]);

    a_r10_no_run_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> !run);
endmodule

bind guard_timer guard_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdt_rst(wdt_rst),
    .run(chk_run), .count(chk_count), .load(chk_load), .ctrl(chk_ctrl),
    .stat(chk_stat)
);

// File: tb/tb_guard_timer.sv
module tb_guard_timer;
    localparam int CLK_P = 10;
    localparam logic [31:0] DEF_LOAD = 32'hFFFF_FFF0;
    localparam int RST_CYC = 8;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic wdt_rst;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    bit m_div, m_run; int m_ratio, m_rc, m_seq, m_pre;
    logic [31:0] m_load, m_count, m_trig;
    int m_pend[5];

    guard_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst));

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        addr = a; #1; v = rdata;
    endtask

    function automatic void model_reset();
        m_div = 0; m_ratio = 0; m_load = DEF_LOAD; m_count = DEF_LOAD; m_trig = 0;
        m_run = 1; m_rc = 0; m_seq = 0; m_pre = 0;
        foreach (m_pend[i]) m_pend[i] = 0;
    endfunction

    function automatic int pbit(input logic [2:0] a);
        case (a)
            3'd1: return 0;
            3'd3: return 2;
            3'd5: return 3;
            3'd6: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic void model_edge(input bit w, input logic [2:0] a,
                                       input logic [31:0] d, input bit t);
        bit en, dis, rel, stp; int lim;
        if (m_rc != 0) begin
            if (m_rc == 1) model_reset();
            else begin
                m_rc--;
                foreach (m_pend[i]) if (m_pend[i] > 0) m_pend[i]--;
            end
            return;
        end
        foreach (m_pend[i]) if (m_pend[i] > 0) m_pend[i]--;
        if (w && pbit(a) >= 0) m_pend[pbit(a)] = 4;
        en = 0; dis = 0;
        if (w && a == 3'd6) begin
            if (m_seq == 1) begin en = (d == 32'h4444); m_seq = 0; end
            else if (m_seq == 2) begin dis = (d == 32'h5555); m_seq = 0; end
            else m_seq = (d == 32'hBBBB) ? 1 : (d == 32'hAAAA) ? 2 : 0;
        end
        rel = w && a == 3'd5 && d != m_trig;
        lim = (1 << m_ratio) - 1;
        stp = m_run && t && (!m_div || m_pre == lim);
        if (rel || en) m_pre = 0;
        else if (m_run && t && m_div) m_pre = (m_pre == lim) ? 0 : m_pre + 1;
        if (rel) m_count = m_load;
        else if (stp) begin
            if (m_count == 32'hFFFF_FFFF) begin
                m_count = 0; m_rc = RST_CYC;
            end else m_count++;
        end
        if (w && a == 3'd1 && !m_run) begin m_div = d[5]; m_ratio = int'(d[4:2]); end
        if (w && a == 3'd3 && !m_run) m_load = d;
        if (w && a == 3'd5) m_trig = d;
        if (en) m_run = 1;
        if (dis) m_run = 0;
        if (m_rc == RST_CYC) m_run = 0;
    endfunction

    task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] d, input bit t);
        we = w; addr = a; wdata = d; tick = t;
        @(posedge clk);
        model_edge(w, a, d, t);
        #1; we = 0; tick = 0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v, st;
        st = 0;
        foreach (m_pend[i]) if (m_pend[i] > 0) st[i] = 1'b1;
        peek(3'd1, v); chk({req, " ctrl"}, v, {26'b0, m_div, 3'(m_ratio), 2'b00});
        peek(3'd2, v); chk({req, " status"}, v, st);
        peek(3'd3, v); chk({req, " load"}, v, m_load);
        peek(3'd4, v); chk({req, " count"}, v, m_count);
        peek(3'd5, v); chk({req, " trig"}, v, m_trig);
        chk({req, " wdt_rst"}, 32'(wdt_rst), 32'(m_rc != 0));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired got hang exp finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int r;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, R2 revision
        check_all("R1");
        peek(3'd0, v); chk("R2 revision", v, 32'h0000_0031);
        // R7 counting while running
        cyc(0, 0, 0, 1); peek(3'd4, v); chk("R7 count step", v, DEF_LOAD + 1);
        cyc(0, 0, 0, 0); peek(3'd4, v); chk("R7 no tick", v, DEF_LOAD + 1);
        // R3 disable
        cyc(1, 3'd6, 32'hAAAA, 0); cyc(1, 3'd6, 32'h5555, 0);
        cyc(0, 0, 0, 1); peek(3'd4, v); chk("R3 R7 stopped holds", v, DEF_LOAD + 1);
        // R5 writes accepted while stopped, R9 busy length
        cyc(1, 3'd3, 32'd1000, 0);
        peek(3'd2, v); chk("R9 load busy set", 32'(v[2]), 1);
        for (int i = 1; i <= 4; i++) begin
            cyc(0, 0, 0, 0);
            peek(3'd2, v); chk("R9 load busy window", 32'(v[2]), (i < 4) ? 1 : 0);
        end
        peek(3'd3, v); chk("R5 load accepted", v, 32'd1000);
        // R6 reload on changed trigger, none on same value
        cyc(1, 3'd5, 32'h1234, 0); peek(3'd4, v); chk("R6 reload", v, 32'd1000);
        cyc(1, 3'd6, 32'hBBBB, 0); cyc(1, 3'd6, 32'h4444, 0);
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
        peek(3'd4, v); chk("R3 enabled counts", v, 32'd1002);
        cyc(1, 3'd5, 32'h1234, 0); peek(3'd4, v); chk("R6 same value ignored", v, 32'd1002);
        // R5 locked while running
        cyc(1, 3'd1, 32'h3C, 0); peek(3'd1, v); chk("R5 ctrl locked", v, 0);
        cyc(1, 3'd3, 32'd7, 0); peek(3'd3, v); chk("R5 load locked", v, 32'd1000);
        // R4 aborted sequences
        cyc(1, 3'd6, 32'hAAAA, 0); cyc(1, 3'd6, 32'h1234, 0); cyc(1, 3'd6, 32'h5555, 0);
        cyc(1, 3'd6, 32'hAAAA, 0); cyc(1, 3'd6, 32'hAAAA, 0); cyc(1, 3'd6, 32'h5555, 0);
        cyc(0, 0, 0, 1); peek(3'd4, v); chk("R4 abort keeps running", v, 32'd1003);
        // R8 prescaler ratio 2 -> every 4 ticks
        cyc(1, 3'd6, 32'hAAAA, 0); cyc(1, 3'd6, 32'h5555, 0);
        cyc(1, 3'd1, 32'h28, 0); cyc(1, 3'd3, 32'd100, 0); cyc(1, 3'd5, 32'h99, 0);
        cyc(1, 3'd6, 32'hBBBB, 0); cyc(1, 3'd6, 32'h4444, 0);
        for (int k = 1; k <= 8; k++) begin
            cyc(0, 0, 0, 1);
            peek(3'd4, v); chk("R8 prescaled count", v, 32'd100 + 32'(k / 4));
        end
        check_all("R8");
        // R10 overflow pulse and restore
        cyc(1, 3'd6, 32'hAAAA, 0); cyc(1, 3'd6, 32'h5555, 0);
        cyc(1, 3'd1, 32'h0, 0); cyc(1, 3'd3, 32'hFFFF_FFFD, 0); cyc(1, 3'd5, 32'h77, 0);
        cyc(1, 3'd6, 32'hBBBB, 0); cyc(1, 3'd6, 32'h4444, 0);
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
        peek(3'd4, v); chk("R10 at top", v, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 1);
        peek(3'd4, v); chk("R10 wrapped", v, 0);
        chk("R10 pulse high", 32'(wdt_rst), 1);
        cyc(1, 3'd3, 32'h5, 0);
        peek(3'd2, v); chk("R10 write ignored in pulse", 32'(v[2]), 0);
        for (int k = 2; k <= RST_CYC; k++) begin
            chk("R10 pulse length", 32'(wdt_rst), (k <= RST_CYC) ? 1 : 0);
            cyc(0, 0, 0, 1);
        end
        chk("R10 pulse ended", 32'(wdt_rst), 0);
        check_all("R10 restore");
        // random mix
        r = $urandom(32'd24680);
        for (int n = 0; n < 4000; n++) begin
            bit w; logic [2:0] a; logic [31:0] d;
            w = ($urandom % 10) < 4;
            a = 3'($urandom % 8);
            case ($urandom % 7)
                0: d = 32'hBBBB;
                1: d = 32'h4444;
                2: d = 32'hAAAA;
                3: d = 32'h5555;
                4: d = $urandom % 16;
                5: d = 32'hFFFF_FFE0 | ($urandom % 32);
                default: d = $urandom;
            endcase
            cyc(w, a, d, $urandom % 2);
            check_all("R3 R4 R5 R6 R7 R8 R9 R10 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule